// File: doc/BRIEF.md
# Perturb-and-Observe Maximum Power Point Tracker

This block searches for the operating point at which a photovoltaic source delivers the most power. Two sampled codes arrive from external converters: the source voltage and the source current. At fixed intervals the block multiplies them to form the present input power and compares that power with the power it stored at the previous step. If the power rose, the block keeps nudging a reference code in the same direction. Otherwise it reverses direction. The reference code drives a PWM duty generator placed downstream.

The output voltage of the converter is also monitored against two limits. Above the regulation threshold, the search is overridden and the reference is stepped downward at each interval. Above the overvoltage limit, the reference drops to the minimum-duty code at once. The reference never leaves the code range that corresponds to 5 % and 90 % duty. The analog front end, the converters and loop compensation are outside the block.

Top module: `mppt_tracker`

## Requirements
- R1: During reset, and in every cycle that follows a cycle with `enable` low, `ref_code` equals REF_MIN = floor(2^RW * 5 / 100), `step_up` is 1 and the stored power is zero.
- R2: While `enable` is high, one update fires every SW_CYC*UPD_PER clocks. `upd_pulse` is high for exactly the one cycle in which `ref_code` first shows the updated value.
- R3: The input power is the full-width unsigned product `v_in * i_in`. If it is strictly greater than the stored power, the direction is kept. If it is equal or smaller, the direction is inverted.
- R4: At an update, `ref_code` moves by STEP codes. The move is upward when the new direction is 1 on `step_up` and downward when it is 0. Between updates `ref_code` only changes by dropping to REF_MIN.
- R5: The product sampled at each update replaces the stored power. This also happens when an overvoltage clamp coincides with that update.
- R6: `ref_code` saturates at REF_MIN and at REF_MAX = floor(2^RW * 90 / 100). It never leaves that range.
- R7: When `v_out > reg_limit` at an update, the direction is forced to 0 and the reference steps downward, whatever the power comparison gives.
- R8: In any enabled cycle with `v_out > ov_limit`, `ref_code` becomes REF_MIN and `step_up` becomes 0 on the next clock. This clamp takes priority over an update that falls in the same cycle.
- R9: When `enable` rises, the timer starts from zero. The first update follows a full SW_CYC*UPD_PER clocks later, and it starts from the R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run the search; low holds the initial state |
| v_in | input | VW | Sampled source voltage code |
| i_in | input | IW | Sampled source current code |
| v_out | input | VW | Sampled converter output voltage code |
| ov_limit | input | VW | Output overvoltage limit code |
| reg_limit | input | VW | Output regulation threshold code |
| ref_code | output | RW | Reference code for the PWM duty generator |
| step_up | output | 1 | Current perturbation direction, 1 = increasing |
| upd_pulse | output | 1 | One-cycle marker of a new reference |

## Verification
Two functions can fall in the same cycle: the periodic update and the overvoltage clamp. The bench counts clocks from an observed update and raises `v_out` above `ov_limit` exactly in the cycle of the next update tick. Two results are then judged. The reference must land on REF_MIN with a falling direction. The stored power must still have been replaced, which shows at the following update: an unchanged product there has to invert the direction, so the reference rises by one step. A second collision is also exercised: the regulation override against a rising power, where the direction must fall although the power grew.

// File: rtl/mppt_tracker.sv
module mppt_tracker #(
  parameter int VW      = 10,
  parameter int IW      = 10,
  parameter int RW      = 10,
  parameter int STEP    = 4,
  parameter int SW_CYC  = 1250,
  parameter int UPD_PER = 256
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic [VW-1:0] v_in,
  input  logic [IW-1:0] i_in,
  input  logic [VW-1:0] v_out,
  input  logic [VW-1:0] ov_limit,
  input  logic [VW-1:0] reg_limit,
  output logic [RW-1:0] ref_code,
  output logic          step_up,
  output logic          upd_pulse
);

  localparam int PW  = VW + IW;
  localparam int SCW = $clog2(SW_CYC + 1);
  localparam int PCW = $clog2(UPD_PER + 1);
  localparam logic [RW-1:0] REF_MIN = RW'((2 ** RW) * 5 / 100);
  localparam logic [RW-1:0] REF_MAX = RW'((2 ** RW) * 90 / 100);

  logic [SCW-1:0] sw_cnt;
  logic [PCW-1:0] per_cnt;
  logic [PW-1:0]  p_now, p_prev;
  logic [RW:0]    up_sum, dn_floor;
  logic [RW-1:0]  ref_up, ref_dn;
  logic           sw_end, per_end, tick, ov_hit, reg_hit, dir_nxt;

  assign p_now    = PW'(v_in) * PW'(i_in);
  assign sw_end   = (sw_cnt == SCW'(SW_CYC - 1));
  assign per_end  = (per_cnt == PCW'(UPD_PER - 1));
  assign tick     = enable && sw_end && per_end;
  assign ov_hit   = (v_out > ov_limit);
  assign reg_hit  = (v_out > reg_limit);
  assign dir_nxt  = reg_hit ? 1'b0 : ((p_now > p_prev) ? step_up : ~step_up);

  assign up_sum   = {1'b0, ref_code} + (RW+1)'(STEP);
  assign dn_floor = {1'b0, REF_MIN} + (RW+1)'(STEP);
  assign ref_up   = (up_sum > {1'b0, REF_MAX}) ? REF_MAX : up_sum[RW-1:0];
  assign ref_dn   = ({1'b0, ref_code} < dn_floor) ? REF_MIN : ref_code - RW'(STEP);

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      sw_cnt    <= '0;
      per_cnt   <= '0;
      p_prev    <= '0;
      step_up   <= 1'b1;
      ref_code  <= REF_MIN;
      upd_pulse <= 1'b0;
    end else begin
      if (sw_end) begin
        sw_cnt  <= '0;
        per_cnt <= per_end ? '0 : per_cnt + 1'b1;
      end else begin
        sw_cnt  <= sw_cnt + 1'b1;
      end
      if (tick) p_prev <= p_now;
      if (ov_hit) begin
        ref_code <= REF_MIN;
        step_up  <= 1'b0;
      end else if (tick) begin
        step_up  <= dir_nxt;
        ref_code <= dir_nxt ? ref_up : ref_dn;
      end
      upd_pulse <= tick;
    end
  end

endmodule

// File: rtl/mppt_tracker_chk.sv
module mppt_tracker_chk #(
  parameter int VW   = 10,
  parameter int RW   = 10,
  parameter int STEP = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          enable,
  input logic [VW-1:0] v_out,
  input logic [VW-1:0] ov_limit,
  input logic [VW-1:0] reg_limit,
  input logic [RW-1:0] ref_code,
  input logic          step_up,
  input logic          upd_pulse
);

  localparam logic [RW-1:0] REF_MIN = RW'((2 ** RW) * 5 / 100);
  localparam logic [RW-1:0] REF_MAX = RW'((2 ** RW) * 90 / 100);

  a_r6_ref_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_code >= REF_MIN) && (ref_code <= REF_MAX));

  a_r8_ov_clamp: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && (v_out > ov_limit)) |=> (ref_code == REF_MIN));

  a_r1_disabled_state: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (ref_code == REF_MIN) && step_up && !upd_pulse);

  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    upd_pulse |=> !upd_pulse);

  a_r4_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_pulse && (ref_code != REF_MIN)) |-> (ref_code == $past(ref_code)));

  a_r4_step_size: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_pulse && ($past(v_out) <= $past(ov_limit))) |->
      (({1'b0, ref_code} == {1'b0, $past(ref_code)} + (RW+1)'(STEP)) ||
       ({1'b0, ref_code} + (RW+1)'(STEP) == {1'b0, $past(ref_code)}) ||
       (ref_code == REF_MIN) || (ref_code == REF_MAX)));

  a_r7_reg_forces_down: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_pulse && ($past(v_out) > $past(reg_limit))) |-> !step_up);

endmodule

bind mppt_tracker mppt_tracker_chk #(.VW(VW), .RW(RW), .STEP(STEP)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .v_out(v_out),
  .ov_limit(ov_limit), .reg_limit(reg_limit), .ref_code(ref_code),
  .step_up(step_up), .upd_pulse(upd_pulse)
);

// File: tb/mppt_tracker_bench.sv
`timescale 1ns/1ps
module mppt_tracker_bench;
  localparam int VW = 8, IW = 8, RW = 10, STEP = 8, SW_CYC = 4, UPD_PER = 8;
  localparam int INTERVAL = SW_CYC * UPD_PER;
  localparam int REF_MIN = (2 ** RW) * 5 / 100;
  localparam int REF_MAX = (2 ** RW) * 90 / 100;
  localparam int OVL = 200, REGL = 150;

  logic clk = 0, rst_n = 0, enable = 0;
  logic [VW-1:0] v_in = 0, v_out = 0, ov_limit = OVL[VW-1:0], reg_limit = REGL[VW-1:0];
  logic [IW-1:0] i_in = 0;
  logic [RW-1:0] ref_code;
  logic step_up, upd_pulse;

  int n_chk = 0, n_fail = 0;
  int mref, mdir, mprev, gap;
  bit done = 0;

  always #4 clk = ~clk;

  mppt_tracker #(.VW(VW), .IW(IW), .RW(RW), .STEP(STEP), .SW_CYC(SW_CYC), .UPD_PER(UPD_PER))
  u_mppt_tracker (.clk(clk), .rst_n(rst_n), .enable(enable), .v_in(v_in), .i_in(i_in),
    .v_out(v_out), .ov_limit(ov_limit), .reg_limit(reg_limit), .ref_code(ref_code),
    .step_up(step_up), .upd_pulse(upd_pulse));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model_init();
    mref = REF_MIN; mdir = 1; mprev = 0;
  endtask

  task automatic wait_pulse(output int cnt);
    cnt = 0;
    do begin
      @(negedge clk);
      cnt++;
    end while (!upd_pulse && cnt < 4 * INTERVAL);
    check(upd_pulse, "R2 pulse seen", int'(upd_pulse), 1);
  endtask

  task automatic do_update(input int v, input int i, input int vo, input string req);
    int p, c;
    v_in = v[VW-1:0]; i_in = i[IW-1:0]; v_out = vo[VW-1:0];
    wait_pulse(c);
    gap = c;
    p = v * i;
    if (vo > REGL) mdir = 0;
    else if (!(p > mprev)) mdir = 1 - mdir;
    if (mdir == 1) mref = (mref + STEP > REF_MAX) ? REF_MAX : mref + STEP;
    else mref = (mref - STEP < REF_MIN) ? REF_MIN : mref - STEP;
    mprev = p;
    check(int'(ref_code) == mref, req, int'(ref_code), mref);
    check(int'(step_up) == mdir, req, int'(step_up), mdir);
  endtask

  task automatic restart();
    @(negedge clk); enable = 0; v_out = 0;
    @(negedge clk); enable = 1;
    model_init();
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check(int'(ref_code) == REF_MIN, "R1 reset ref", int'(ref_code), REF_MIN);
    check(step_up == 1'b1, "R1 reset dir", int'(step_up), 1);
    check(upd_pulse == 1'b0, "R1 reset pulse", int'(upd_pulse), 0);
  endtask

  task automatic t_enable_timing();
    int c;
    @(negedge clk); rst_n = 1; enable = 1; model_init();
    v_in = 10; i_in = 10; v_out = 0;
    wait_pulse(c);
    check(c == INTERVAL, "R9 first update delay", c, INTERVAL);
    mdir = 1; mref = REF_MIN + STEP; mprev = 100;
    check(int'(ref_code) == mref, "R4 first step up", int'(ref_code), mref);
    do_update(11, 10, 0, "R3 rising keeps dir");
    check(gap == INTERVAL, "R2 update period", gap, INTERVAL);
    do_update(11, 10, 0, "R3 equal power flips");
    do_update(9, 10, 0, "R3 falling flips");
  endtask

  task automatic t_full_width();
    restart();
    do_update(255, 254, 0, "R3 wide product");
    do_update(255, 255, 0, "R3 wide product greater");
    do_update(255, 255, 0, "R3 wide product equal");
  endtask

  task automatic t_sat_min();
    restart();
    do_update(0, 0, 0, "R6 zero power floor");
    do_update(0, 0, 0, "R6 floor flips up");
    do_update(0, 0, 0, "R6 floor again");
  endtask

  task automatic t_sat_max();
    restart();
    for (int k = 1; k <= 115; k++) do_update(k, 200, 0, "R6 climb to ceiling");
    check(int'(ref_code) == REF_MAX, "R6 ceiling held", int'(ref_code), REF_MAX);
  endtask

  task automatic t_regulation();
    do_update(120, 210, 160, "R7 regulation forces down");
    do_update(121, 210, 160, "R7 regulation despite rise");
    do_update(122, 210, 0, "R7 released");
  endtask

  task automatic t_ov_mid();
    @(negedge clk); @(negedge clk);
    v_out = 210;
    @(negedge clk);
    check(int'(ref_code) == REF_MIN, "R8 ov clamp ref", int'(ref_code), REF_MIN);
    check(step_up == 1'b0, "R8 ov clamp dir", int'(step_up), 0);
    v_out = 0;
    mref = REF_MIN; mdir = 0;
    do_update(50, 50, 0, "R5 after ov prev untouched");
  endtask

  task automatic t_ov_collide();
    int c;
    restart();
    do_update(30, 30, 0, "R4 pre collision");
    v_in = 40; i_in = 40;
    repeat (INTERVAL - 1) @(negedge clk);
    v_out = 210;
    wait_pulse(c);
    check(int'(ref_code) == REF_MIN, "R8 ov wins over update", int'(ref_code), REF_MIN);
    check(step_up == 1'b0, "R8 ov wins dir", int'(step_up), 0);
    v_out = 0;
    mref = REF_MIN; mdir = 0; mprev = 1600;
    do_update(40, 40, 0, "R5 power stored under ov");
  endtask

  task automatic t_disable();
    @(negedge clk); enable = 0;
    @(negedge clk);
    check(int'(ref_code) == REF_MIN, "R1 disable ref", int'(ref_code), REF_MIN);
    check(step_up == 1'b1, "R1 disable dir", int'(step_up), 1);
    repeat (2 * INTERVAL) @(negedge clk);
    check(upd_pulse == 1'b0 && int'(ref_code) == REF_MIN, "R9 idle while disabled",
          int'(ref_code), REF_MIN);
  endtask

  initial begin
    t_reset();
    t_enable_timing();
    t_full_width();
    t_sat_min();
    t_sat_max();
    t_regulation();
    t_ov_mid();
    t_ov_collide();
    t_disable();
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule